// File: doc/BRIEF.md
# Cascaded Compare Timer with Line-Coding Output

This block is a 12-bit compare timer made of a 4-bit low stage and an 8-bit high stage. Each stage has its own compare register. In split mode the low stage acts as a prescaler: each low-stage match advances the high stage once, and a high-stage match is the timer event. In fused mode both stages form one 12-bit counter, which is checked against the two compare registers joined together. After a timer event the counter restarts from zero, so the event period is set by the compare values.

Every timer event inverts an output flip-flop. A 3-bit output-select field chooses what drives the timer output pin. The choices are: the flip-flop itself; a burst signal gated by the flip-flop or by the serial data bit; Manchester or biphase line coding of the serial data bit, where timer events mark the half-bit boundaries; the serial bit passed straight through; or a PWM level. The block also drives an interrupt pulse, a port-enable flag that requests the pin's alternate function, and an error flag for the forbidden select code.

Software programs the block through a small register write port. Address 0 is the control register: bit 0 starts counting, bit 1 selects fused mode, bits 4:2 hold the output select, and bit 5 enables the interrupt. Address 1 holds the low compare value in bits 3:0. Address 2 holds the high compare value in bits 7:0.

Top module: `cmp_timer_top`

## Requirements
- R1: A synchronous active-high reset clears the counters, the output flip-flop, the compare registers and the control register. After reset `tmr_out`=0, `irq`=0, `port_en`=0 and `mode_err`=1.
- R2: In split mode (control bit 1 = 0), the high stage advances only on a low-stage match. The timer event then recurs every (low compare + 1) × (high compare + 1) cycles.
- R3: In fused mode (control bit 1 = 1), the compare value is {high compare, low compare}, with the low register supplying bits 3:0. An event fires only when all 12 bits equal the count, and it recurs every value + 1 cycles.
- R4: In select code 111, each timer event inverts the output flip-flop, and the flip-flop drives `tmr_out`.
- R5: A write to a compare register suppresses any event that would fire in the same cycle. In fused mode a write to either compare register suppresses the event. A write to the control register does not suppress events.
- R6: With control bit 5 set, `irq` is high for one cycle, in the same cycle that the output flip-flop changes. With bit 5 clear, `irq` stays low.
- R7: Select code 110 gives `burst_in` AND the flip-flop. Select code 101 gives `burst_in` AND `sdata`.
- R8: Select code 011 (Manchester) outputs `sdata` in the first half-bit and its inverse in the second half-bit. Each half-bit lasts one event period, and the first half-bit begins at reset.
- R9: Select code 100 (biphase) inverts the output at every bit boundary. It adds a mid-bit inversion only when `sdata` is 0.
- R10: Select code 010 makes `tmr_out` equal to `sdata`.
- R11: Select code 001 (PWM) drives the output high while the count is below the compare value. In split mode this uses the 8-bit high stage; in fused mode it uses the full 12 bits.
- R12: Select code 000 holds `tmr_out` low and sets `mode_err`. `port_en` is high exactly when the select code is not 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 low compare, 2 high compare) |
| wr_data | input | 8 | Register write data |
| sdata | input | 1 | Serial data bit to pass or encode |
| burst_in | input | 1 | Burst generator signal |
| tmr_out | output | 1 | Timer output pin level |
| irq | output | 1 | Interrupt pulse |
| port_en | output | 1 | Alternate-function enable for the output pin |
| mode_err | output | 1 | Forbidden select code is loaded |

## Verification
The assertions assume the following about the inputs:
- `rst` is the only way to clear state.
- `sdata` and `burst_in` change only between clock edges.
- For the biphase edge rule, `sdata` stays constant across a whole bit.

The stimulus follows these assumptions:
- It changes every input only on the falling edge.
- It holds `sdata` fixed for each coding run.
- It changes the output mode only after a fresh reset, so the flip-flop's half-bit phase is always known when a coding check starts.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int LO_W_DEF   = 4;
    localparam int HI_W_DEF   = 8;
    localparam int ADDR_W_DEF = 2;
    localparam int DATA_W_DEF = 8;

    localparam int A_CTRL   = 0;
    localparam int A_CMP_LO = 1;
    localparam int A_CMP_HI = 2;

    typedef enum logic [2:0] {
        OS_OFF     = 3'b000,
        OS_PWM     = 3'b001,
        OS_PASS    = 3'b010,
        OS_MANCH   = 3'b011,
        OS_BIPH    = 3'b100,
        OS_BRST_SD = 3'b101,
        OS_BRST_FF = 3'b110,
        OS_TOGGLE  = 3'b111
    } osel_e;

    typedef struct packed {
        logic  irq_en;
        osel_e osel;
        logic  fuse;
        logic  run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic mode_active(osel_e o);
        return o != OS_OFF;
    endfunction

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int LO_W   = LO_W_DEF,
    parameter int HI_W   = HI_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic [LO_W-1:0]   cmp_lo_q,
    output logic [HI_W-1:0]   cmp_hi_q,
    output logic              wr_lo,
    output logic              wr_hi
);

    assign wr_lo = wr_en && (wr_addr == ADDR_W'(A_CMP_LO));
    assign wr_hi = wr_en && (wr_addr == ADDR_W'(A_CMP_HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_CTRL))
                ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_lo)
                cmp_lo_q <= wr_data[LO_W-1:0];
            if (wr_hi)
                cmp_hi_q <= wr_data[HI_W-1:0];
        end
    end

endmodule

// File: rtl/cmp_timer_stages.sv
module cmp_timer_stages #(
    parameter int LO_W = 4,
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            fuse,
    input  logic [LO_W-1:0] cmp_lo,
    input  logic [HI_W-1:0] cmp_hi,
    input  logic            wr_lo,
    input  logic            wr_hi,
    output logic            evt,
    output logic            pwm_lvl
);

    localparam int FW = LO_W + HI_W;

    logic [LO_W-1:0] cnt_lo;
    logic [HI_W-1:0] cnt_hi;
    logic [FW-1:0]   cnt_f;
    logic [FW-1:0]   cmp_f;
    logic            lo_hit, hi_hit, f_hit;
    logic            lo_evt, hi_evt, f_evt;

    assign cnt_f  = {cnt_hi, cnt_lo};
    assign cmp_f  = {cmp_hi, cmp_lo};
    assign lo_hit = (cnt_lo == cmp_lo);
    assign hi_hit = (cnt_hi == cmp_hi);
    assign f_hit  = (cnt_f == cmp_f);

    // Matches coinciding with a compare write are dropped.
    assign lo_evt = run && !fuse && lo_hit && !wr_lo;
    assign hi_evt = lo_evt && hi_hit && !wr_hi;
    assign f_evt  = run && fuse && f_hit && !(wr_lo || wr_hi);
    assign evt    = fuse ? f_evt : hi_evt;

    assign pwm_lvl = fuse ? (cnt_f < cmp_f) : (cnt_hi < cmp_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (run) begin
            if (fuse) begin
                {cnt_hi, cnt_lo} <= f_evt ? '0 : cnt_f + 1'b1;
            end else begin
                cnt_lo <= lo_evt ? '0 : cnt_lo + 1'b1;
                if (lo_evt)
                    cnt_hi <= hi_evt ? '0 : cnt_hi + 1'b1;
            end
        end
    end

    // R2: in split mode the high stage only moves on a low-stage match
    a_r2_hi_hold: assert property (@(posedge clk) disable iff (rst)
        (!fuse && !lo_evt) |=> ($stable(cnt_hi) || rst));

    // R3: a fused match restarts the whole 12-bit count
    a_r3_fused_reload: assert property (@(posedge clk) disable iff (rst)
        (fuse && evt) |=> ((cnt_f == '0) || rst));

endmodule

// File: rtl/cmp_timer_outmux.sv
module cmp_timer_outmux
    import cmp_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  evt,
    input  logic  pwm_lvl,
    input  logic  sdata,
    input  logic  burst_in,
    input  osel_e osel,
    output logic  tmr_out,
    output logic  flop_q
);

    logic bp_q;

    // flop_q doubles as the half-bit phase: 0 = first half of a bit
    always_ff @(posedge clk) begin
        if (rst) begin
            flop_q <= 1'b0;
            bp_q   <= 1'b0;
        end else if (evt) begin
            flop_q <= ~flop_q;
            if (flop_q || !sdata)
                bp_q <= ~bp_q;
        end
    end

    always_comb begin
        case (osel)
            OS_TOGGLE:  tmr_out = flop_q;
            OS_BRST_FF: tmr_out = burst_in & flop_q;
            OS_BRST_SD: tmr_out = burst_in & sdata;
            OS_BIPH:    tmr_out = bp_q;
            OS_MANCH:   tmr_out = sdata ^ flop_q;
            OS_PASS:    tmr_out = sdata;
            OS_PWM:     tmr_out = pwm_lvl;
            default:    tmr_out = 1'b0;
        endcase
    end

    // R4: every event flips the output flip-flop
    a_r4_flop_flips: assert property (@(posedge clk) disable iff (rst)
        evt |=> ((flop_q != $past(flop_q)) || rst));

    // R9: biphase line always changes at a bit boundary
    a_r9_bit_edge: assert property (@(posedge clk) disable iff (rst)
        (evt && flop_q && osel == OS_BIPH) |=> ((bp_q != $past(bp_q)) || rst));

    // R10: passthrough follows the serial bit
    a_r10_pass: assert property (@(posedge clk) disable iff (rst)
        (osel == OS_PASS) |-> (tmr_out == sdata));

    // R12: forbidden code keeps the pin low
    a_r12_off_low: assert property (@(posedge clk) disable iff (rst)
        (osel == OS_OFF) |-> !tmr_out);

endmodule

// File: rtl/cmp_timer_top.sv
module cmp_timer_top
    import cmp_timer_pkg::*;
#(
    parameter int LO_W   = LO_W_DEF,
    parameter int HI_W   = HI_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sdata,
    input  logic              burst_in,
    output logic              tmr_out,
    output logic              irq,
    output logic              port_en,
    output logic              mode_err
);

    ctrl_t           ctrl_q;
    logic [LO_W-1:0] cmp_lo_q;
    logic [HI_W-1:0] cmp_hi_q;
    logic            wr_lo, wr_hi;
    logic            evt, pwm_lvl, flop_q;

    cmp_timer_regs #(
        .LO_W(LO_W), .HI_W(HI_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_q(ctrl_q), .cmp_lo_q(cmp_lo_q),
        .cmp_hi_q(cmp_hi_q), .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    cmp_timer_stages #(
        .LO_W(LO_W), .HI_W(HI_W)
    ) stages_i (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .fuse(ctrl_q.fuse),
        .cmp_lo(cmp_lo_q), .cmp_hi(cmp_hi_q), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .evt(evt), .pwm_lvl(pwm_lvl)
    );

    cmp_timer_outmux outmux_i (
        .clk(clk), .rst(rst), .evt(evt), .pwm_lvl(pwm_lvl), .sdata(sdata),
        .burst_in(burst_in), .osel(ctrl_q.osel), .tmr_out(tmr_out),
        .flop_q(flop_q)
    );

    assign port_en  = mode_active(ctrl_q.osel);
    assign mode_err = !port_en;

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= evt && ctrl_q.irq_en;
    end

    // R6: an interrupt pulse always coincides with a flip-flop change
    a_r6_irq_with_flop: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flop_q != $past(flop_q)));

    // R6: interrupt is a single-cycle pulse
    a_r6_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> (!irq || rst || $past(ctrl_q.fuse && cmp_lo_q == '0 && cmp_hi_q == '0)
                 || $past(!ctrl_q.fuse && cmp_lo_q == '0 && cmp_hi_q == '0)));

endmodule

// File: tb/cmp_timer_top_tb_top.sv
module cmp_timer_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sdata = 1'b0;
    logic       burst_in = 1'b0;
    logic       tmr_out, irq, port_en, mode_err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cmp_timer_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sdata(sdata), .burst_in(burst_in),
        .tmr_out(tmr_out), .irq(irq), .port_en(port_en), .mode_err(mode_err)
    );

    // {fuse, low compare, high compare, expected edge gap}
    localparam logic [31:0] VEC [6] = '{
        32'h00_03_02_0C,
        32'h00_00_00_01,
        32'h01_05_01_16,
        32'h00_0F_00_10,
        32'h01_00_00_01,
        32'h00_01_04_0A
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg(input logic fuse, input logic [3:0] lo, input logic [7:0] hi,
                       input logic [2:0] os, input logic ien);
        do_reset();
        wr(2'd1, {4'h0, lo});
        wr(2'd2, hi);
        wr(2'd0, {2'b00, ien, os, fuse, 1'b1});
    endtask

    task automatic edge_gap(output int gap);
        logic p;
        int n;
        gap = -1;
        p = tmr_out; n = 0;
        while (tmr_out == p && n < 5000) begin @(negedge clk); n++; end
        p = tmr_out; n = 0;
        while (tmr_out == p && n < 5000) begin @(negedge clk); n++; end
        if (n < 5000) gap = n;
    endtask

    task automatic watch(input int cyc, output int hi, output int edges,
                         output int irqs, output int bad);
        logic p;
        hi = 0; edges = 0; irqs = 0; bad = 0;
        p = tmr_out;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (tmr_out != p) edges++;
            if (irq) irqs++;
            if (irq && tmr_out == p) bad++;
            if (tmr_out) hi++;
            p = tmr_out;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int g, h, e, q, b;

        // R1 reset state
        do_reset();
        chk("R1 out", tmr_out, 0);
        chk("R1 irq", irq, 0);
        chk("R1 port_en", port_en, 0);
        chk("R1 mode_err", mode_err, 1);

        // R2 / R3 / R4 period table
        for (int i = 0; i < 6; i++) begin
            cfg(VEC[i][24], VEC[i][19:16], VEC[i][15:8], 3'b111, 1'b0);
            edge_gap(g);
            chk(VEC[i][24] ? "R3 R4 fused period" : "R2 R4 split period", g, int'(VEC[i][7:0]));
        end

        // R1 reset mid-run clears mode and flop
        cfg(1'b1, 4'd2, 8'd0, 3'b111, 1'b0);
        repeat (4) @(negedge clk);
        do_reset();
        chk("R1 out after run", tmr_out, 0);
        chk("R1 port_en after run", port_en, 0);
        watch(20, h, e, q, b);
        chk("R1 no counting after reset", e, 0);

        // R12 forbidden code
        cfg(1'b1, 4'd0, 8'd0, 3'b000, 1'b1);
        sdata = 1'b1; burst_in = 1'b1;
        watch(20, h, e, q, b);
        chk("R12 out low", h, 0);
        chk("R12 mode_err", mode_err, 1);
        chk("R12 port_en low", port_en, 0);
        cfg(1'b1, 4'd0, 8'd0, 3'b111, 1'b0);
        chk("R12 port_en active", port_en, 1);
        chk("R12 mode_err clear", mode_err, 0);

        // R10 passthrough
        cfg(1'b1, 4'd3, 8'd0, 3'b010, 1'b0);
        sdata = 1'b1; #1;
        chk("R10 pass 1", tmr_out, 1);
        @(negedge clk); sdata = 1'b0; #1;
        chk("R10 pass 0", tmr_out, 0);

        // R7 burst gated by serial data
        cfg(1'b1, 4'd3, 8'd0, 3'b101, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            burst_in = k[0]; sdata = k[1]; #1;
            chk("R7 burst and sdata", tmr_out, k[0] & k[1]);
        end

        // R7 burst gated by flip-flop
        burst_in = 1'b1;
        cfg(1'b1, 4'd3, 8'd0, 3'b110, 1'b0);
        watch(40, h, e, q, b);
        chk("R7 burst and flop on", h, 20);
        burst_in = 1'b0;
        watch(40, h, e, q, b);
        chk("R7 burst and flop off", h, 0);

        // R8 Manchester
        sdata = 1'b1;
        cfg(1'b1, 4'd3, 8'd0, 3'b011, 1'b0);
        chk("R8 first half data 1", tmr_out, 1);
        edge_gap(g);
        chk("R8 half-bit gap", g, 4);
        sdata = 1'b0;
        cfg(1'b1, 4'd3, 8'd0, 3'b011, 1'b0);
        chk("R8 first half data 0", tmr_out, 0);
        while (tmr_out == 1'b0) @(negedge clk);
        chk("R8 second half inverse", tmr_out, 1);

        // R9 biphase
        sdata = 1'b1;
        cfg(1'b1, 4'd3, 8'd0, 3'b100, 1'b0);
        edge_gap(g);
        chk("R9 data 1 boundary only", g, 8);
        sdata = 1'b0;
        cfg(1'b1, 4'd3, 8'd0, 3'b100, 1'b0);
        edge_gap(g);
        chk("R9 data 0 mid-bit", g, 4);

        // R11 PWM
        cfg(1'b0, 4'd0, 8'd3, 3'b001, 1'b0);
        watch(40, h, e, q, b);
        chk("R11 8-bit duty", h, 30);
        cfg(1'b1, 4'd5, 8'd0, 3'b001, 1'b0);
        watch(60, h, e, q, b);
        chk("R11 12-bit duty", h, 50);

        // R5 suppression by compare writes
        cfg(1'b1, 4'd3, 8'd0, 3'b111, 1'b0);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd3;
        watch(40, h, e, q, b);
        wr_en = 1'b0;
        chk("R5 low write suppresses", e, 0);
        cfg(1'b1, 4'd3, 8'd0, 3'b111, 1'b0);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd0;
        watch(40, h, e, q, b);
        wr_en = 1'b0;
        chk("R5 high write suppresses", e, 0);
        cfg(1'b1, 4'd3, 8'd0, 3'b111, 1'b0);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = {2'b00, 1'b0, 3'b111, 1'b1, 1'b1};
        watch(40, h, e, q, b);
        wr_en = 1'b0;
        chk("R5 control write no effect", e, 10);

        // R6 interrupt
        cfg(1'b1, 4'd3, 8'd0, 3'b111, 1'b1);
        watch(40, h, e, q, b);
        chk("R6 irq count", q, 10);
        chk("R6 irq aligned", b, 0);
        cfg(1'b1, 4'd3, 8'd0, 3'b111, 1'b0);
        watch(40, h, e, q, b);
        chk("R6 irq disabled", q, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule